// File: doc/BRIEF.md
# Move-Elimination Reference Tracker

This block sits beside the register rename stage. When rename finds a register-to-register move, it asks the tracker whether the move can be eliminated. An eliminated move uses no execution unit and gets no new physical entry: the destination's mapping simply points at the source's physical entry. The rename table itself lives elsewhere. The tracker only keeps the bookkeeping that makes such sharing safe. It has a small, fixed pool of tracking slots. Each slot holds the tag of one physical entry that two or more architectural registers share, a speculative reference count and a retired reference count. Because the pool is small, elimination is opportunistic. If no slot is free, or the shared entry already carries the most references a slot can count, the tracker refuses and rename sends the move down the normal path with a freshly allocated entry.

Retirement reports two kinds of events:
- the retirement of an eliminated move, which raises the retired count;
- the retirement of an instruction that overwrote an alias, which drops one reference in both views.

For an overwrite, the tracker answers in the same cycle whether the old physical entry may now go to the free list. That is allowed only when no other reference to it is still tracked. A slot returns to the pool when its count falls to one. A flush throws away all speculative references: every count returns to its retired value, and slots that only discarded moves were holding are released.

The query port carries only a valid strobe and a tag, and the answer comes back combinationally in the same cycle. Nothing can stall it, so the port has no ready signal and no back-pressure. The two retirement ports are plain strobes with tags.

Top module: `me_ref_tracker`

## Requirements
- R1: After reset every slot is free. A release of any tag answers `rl_free`=1, and the first valid query of any tag answers `q_elim`=1.
- R2: A valid query for an untracked tag, when a slot is free and `flush`=0, gives `q_elim`=1 in the same cycle. A slot then tracks that tag with speculative count 2 and retired count 1.
- R3: A valid query for a tracked tag whose speculative count is below MAX_REFS gives `q_elim`=1 and raises the count by one. At most one move is eliminated per cycle.
- R4: A valid query for a tracked tag whose speculative count equals MAX_REFS gives `q_elim`=0 and changes nothing.
- R5: A valid query for an untracked tag while all SLOTS slots are in use gives `q_elim`=0. Once a slot is released, the same query is eliminated.
- R6: A release (`rl_valid`=1) of a tracked tag gives `rl_free`=0 and lowers both counts by one. The retired count never goes below 1. When the speculative count reaches 1, the slot is released. A release of an untracked tag gives `rl_free`=1, and with `rl_valid`=0 `rl_free` is 0.
- R7: A move retirement (`rm_valid`=1) of a tracked tag raises its retired count by one, but never above the speculative count. It has no effect on an untracked tag.
- R8: On `flush`=1, `q_elim` is 0. Each slot's speculative count becomes its retired count, after that cycle's retirement events. Slots left with a count below 2 are released.
- R9: With `q_valid`=0, `q_elim` is 0 and no count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | 1 | Rename presents a move for elimination |
| q_src_tag | input | PTAG_W | Physical tag of the move's source |
| q_elim | output | 1 | Same-cycle answer: the move is eliminated |
| rm_valid | input | 1 | An eliminated move retires |
| rm_tag | input | PTAG_W | Physical tag that move shared |
| rl_valid | input | 1 | An instruction that overwrote an alias retires |
| rl_tag | input | PTAG_W | Physical tag of the overwritten mapping |
| rl_free | output | 1 | Same-cycle answer: the tag may go to the free list |
| flush | input | 1 | Discard all speculative references |

## Verification
Directed sequences drive one tag through every count, from allocation up to the MAX_REFS cap and back down by releases. This separates correct counting from off-by-one errors at the cap and at the point where a slot is freed. Filling every slot with distinct tags and then asking for one more tells a correct free-slot search apart from one that overwrites a live slot. Flush sequences use one tag whose move has retired and one whose move has not, so rolling back to the retired count is distinguished from clearing everything. A long pseudo-random mix then runs queries, retirements, releases and flushes over a few tags, so the same cycle often carries several events for the same slot. It compares both answers every cycle with an arithmetic count model.

// File: rtl/me_pkg.sv
package me_pkg;
  localparam int unsigned DEF_SLOTS    = 4;
  localparam int unsigned DEF_PTAG_W   = 7;
  localparam int unsigned DEF_MAX_REFS = 4;

  typedef enum logic [1:0] {
    SLOT_HOLD  = 2'd0,
    SLOT_ALLOC = 2'd1,
    SLOT_UPD   = 2'd2
  } slot_op_e;
endpackage

// File: rtl/me_match.sv
module me_match #(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned PTAG_W = 7
) (
  input  logic                           en,
  input  logic [PTAG_W-1:0]              probe,
  input  logic [SLOTS-1:0]               live,
  input  logic [SLOTS-1:0][PTAG_W-1:0]   tags,
  output logic [SLOTS-1:0]               hit,
  output logic                           any
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    assign hit[i] = en && live[i] && (tags[i] == probe);
  end
  assign any = |hit;
endmodule

// File: rtl/me_alloc.sv
module me_alloc #(
  parameter int unsigned SLOTS = 4
) (
  input  logic [SLOTS-1:0] free_vec,
  output logic [SLOTS-1:0] grant,
  output logic             any_free
);
  logic [SLOTS:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < SLOTS; i++) begin : g_pick
    assign grant[i]  = free_vec[i] && !seen[i];
    assign seen[i+1] = seen[i] || free_vec[i];
  end
  assign any_free = seen[SLOTS];
endmodule

// File: rtl/me_slot.sv
module me_slot
  import me_pkg::*;
#(
  parameter int unsigned PTAG_W   = 7,
  parameter int unsigned MAX_REFS = 4,
  localparam int unsigned CNT_W   = $clog2(MAX_REFS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [PTAG_W-1:0] alloc_tag,
  input  logic              inc,
  input  logic              mv_inc,
  input  logic              rel_dec,
  input  logic              flush,
  output logic              live,
  output logic [PTAG_W-1:0] tag,
  output logic              at_max
);
  logic [CNT_W-1:0] spec_q, ret_q, spec_n, ret_n;
  logic [PTAG_W-1:0] tag_q;
  slot_op_e op;

  assign live   = spec_q >= CNT_W'(2);
  assign tag    = tag_q;
  assign at_max = spec_q >= CNT_W'(MAX_REFS);

  always_comb begin
    if (alloc)     op = SLOT_ALLOC;
    else if (live) op = SLOT_UPD;
    else           op = SLOT_HOLD;
  end

  always_comb begin
    spec_n = spec_q;
    ret_n  = ret_q;
    unique case (op)
      SLOT_ALLOC: begin
        spec_n = CNT_W'(2);
        ret_n  = CNT_W'(1);
      end
      SLOT_UPD: begin
        if (inc) spec_n = spec_n + CNT_W'(1);
        if (mv_inc && (ret_q < spec_q)) ret_n = ret_n + CNT_W'(1);
        if (rel_dec) begin
          spec_n = spec_n - CNT_W'(1);
          if (ret_n > CNT_W'(1)) ret_n = ret_n - CNT_W'(1);
        end
        if (flush) spec_n = ret_n;
        if (spec_n < CNT_W'(2)) begin
          spec_n = '0;
          ret_n  = '0;
        end
      end
      default: begin
        spec_n = '0;
        ret_n  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spec_q <= '0;
      ret_q  <= '0;
      tag_q  <= '0;
    end else begin
      spec_q <= spec_n;
      ret_q  <= ret_n;
      if (alloc) tag_q <= alloc_tag;
    end
  end

  // R4: a slot never counts past its cap
  a_r4_cap_held: assert property (@(posedge clk) disable iff (!rst_n)
    spec_q <= CNT_W'(MAX_REFS));

  // R7: retired view never exceeds speculative view
  a_r7_ret_le_spec: assert property (@(posedge clk) disable iff (!rst_n)
    ret_q <= spec_q);

  // R8: after a flush cycle both views agree
  a_r8_flush_restore: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (spec_q == ret_q));

  // R2: a slot is never allocated while in use
  a_r2_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !live);
endmodule

// File: rtl/me_ref_tracker.sv
module me_ref_tracker
  import me_pkg::*;
#(
  parameter int unsigned SLOTS    = DEF_SLOTS,
  parameter int unsigned PTAG_W   = DEF_PTAG_W,
  parameter int unsigned MAX_REFS = DEF_MAX_REFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_valid,
  input  logic [PTAG_W-1:0] q_src_tag,
  output logic              q_elim,
  input  logic              rm_valid,
  input  logic [PTAG_W-1:0] rm_tag,
  input  logic              rl_valid,
  input  logic [PTAG_W-1:0] rl_tag,
  output logic              rl_free,
  input  logic              flush
);
  logic [SLOTS-1:0]             live, at_max, grant;
  logic [SLOTS-1:0][PTAG_W-1:0] tags;
  logic [SLOTS-1:0]             q_hit, mv_hit, rl_hit, alloc, inc;
  logic q_any, mv_any, rl_any, any_free, q_cap;

  me_match #(.SLOTS(SLOTS), .PTAG_W(PTAG_W)) u_q_match (
    .en(q_valid), .probe(q_src_tag), .live(live), .tags(tags),
    .hit(q_hit), .any(q_any));
  me_match #(.SLOTS(SLOTS), .PTAG_W(PTAG_W)) u_mv_match (
    .en(rm_valid), .probe(rm_tag), .live(live), .tags(tags),
    .hit(mv_hit), .any(mv_any));
  me_match #(.SLOTS(SLOTS), .PTAG_W(PTAG_W)) u_rl_match (
    .en(rl_valid), .probe(rl_tag), .live(live), .tags(tags),
    .hit(rl_hit), .any(rl_any));

  me_alloc #(.SLOTS(SLOTS)) u_alloc (
    .free_vec(~live), .grant(grant), .any_free(any_free));

  assign q_cap  = |(q_hit & at_max);
  assign q_elim = q_valid && !flush && (q_any ? !q_cap : any_free);
  assign rl_free = rl_valid && !rl_any;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign inc[i]   = q_elim && q_hit[i];
    assign alloc[i] = q_elim && !q_any && grant[i];
    me_slot #(.PTAG_W(PTAG_W), .MAX_REFS(MAX_REFS)) u_slot (
      .clk(clk), .rst_n(rst_n), .alloc(alloc[i]), .alloc_tag(q_src_tag),
      .inc(inc[i]), .mv_inc(mv_hit[i]), .rel_dec(rl_hit[i]), .flush(flush),
      .live(live[i]), .tag(tags[i]), .at_max(at_max[i]));
  end

  // checker state: remembers a fresh allocation for one cycle
  logic              chk_alloc;
  logic [PTAG_W-1:0] chk_tag;
  logic [SLOTS-1:0]  chk_hit;
  logic              chk_any;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_alloc <= 1'b0;
      chk_tag   <= '0;
    end else begin
      chk_alloc <= q_elim && !q_any;
      chk_tag   <= q_src_tag;
    end
  end
  me_match #(.SLOTS(SLOTS), .PTAG_W(PTAG_W)) u_chk_match (
    .en(1'b1), .probe(chk_tag), .live(live), .tags(tags),
    .hit(chk_hit), .any(chk_any));

  // R2: a newly eliminated untracked tag is tracked next cycle
  a_r2_alloc_tracked: assert property (@(posedge clk) disable iff (!rst_n)
    chk_alloc |-> chk_any);
  // R3: a tag lives in at most one slot
  a_r3_unique_tag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_hit) && $onehot0(rl_hit) && $onehot0(chk_hit));
  // R3: one elimination per cycle
  a_r3_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc | inc));
  // R5: full table and miss refuses
  a_r5_full_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_any && (&live)) |-> !q_elim);
  // R6: a tracked release never frees the entry
  a_r6_shared_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rl_valid && rl_any) |-> !rl_free);
  // R8: no elimination during flush
  a_r8_flush_block: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !q_elim);
  // R9: idle query port
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |-> !q_elim);
endmodule

// File: tb/me_ref_tracker_bench.sv
module me_ref_tracker_bench;
  localparam int SLOTS = 4;
  localparam int PTAG_W = 4;
  localparam int MAXR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q_valid = 0, rm_valid = 0, rl_valid = 0, flush = 0;
  logic [PTAG_W-1:0] q_src_tag = '0, rm_tag = '0, rl_tag = '0;
  logic q_elim, rl_free;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_tag [SLOTS];
  int m_spec[SLOTS];
  int m_ret [SLOTS];

  always #10 clk = ~clk;

  me_ref_tracker #(.SLOTS(SLOTS), .PTAG_W(PTAG_W), .MAX_REFS(MAXR)) u_me_ref_tracker (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_src_tag(q_src_tag),
    .q_elim(q_elim), .rm_valid(rm_valid), .rm_tag(rm_tag),
    .rl_valid(rl_valid), .rl_tag(rl_tag), .rl_free(rl_free), .flush(flush));

  function automatic int find(int t);
    for (int i = 0; i < SLOTS; i++)
      if (m_spec[i] >= 2 && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic int first_free();
    for (int i = 0; i < SLOTS; i++)
      if (m_spec[i] < 2) return i;
    return -1;
  endfunction

  function automatic bit pred_elim(bit qv, int qt, bit fl);
    int h;
    h = find(qt);
    if (!qv || fl) return 0;
    if (h >= 0) return m_spec[h] < MAXR;
    return first_free() >= 0;
  endfunction

  task automatic model_update(bit qv, int qt, bit mv, int mt, bit rv, int rt, bit fl);
    int qh, mh, rh, ff;
    bit el;
    el = pred_elim(qv, qt, fl);
    qh = find(qt); mh = mv ? find(mt) : -1; rh = rv ? find(rt) : -1;
    ff = first_free();
    for (int i = 0; i < SLOTS; i++) begin
      if (m_spec[i] >= 2) begin
        int s, r;
        s = m_spec[i]; r = m_ret[i];
        if (el && qh == i) s = s + 1;
        if (mh == i && m_ret[i] < m_spec[i]) r = r + 1;
        if (rh == i) begin s = s - 1; if (r > 1) r = r - 1; end
        if (fl) s = r;
        if (s < 2) begin s = 0; r = 0; end
        m_spec[i] = s; m_ret[i] = r;
      end
    end
    if (el && qh < 0) begin
      m_tag[ff] = qt; m_spec[ff] = 2; m_ret[ff] = 1;
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ee/ef: explicit expectation, -1 means use the count model
  task automatic step(bit qv, int qt, bit mv, int mt, bit rv, int rt, bit fl,
                      int ee, int ef, string req);
    int pe, pf;
    q_valid = qv; q_src_tag = PTAG_W'(qt);
    rm_valid = mv; rm_tag = PTAG_W'(mt);
    rl_valid = rv; rl_tag = PTAG_W'(rt);
    flush = fl;
    #2;
    pe = pred_elim(qv, qt, fl);
    pf = (rv && find(rt) < 0) ? 1 : 0;
    if (ee >= 0) check(req, "q_elim vs requirement", int'(q_elim), ee);
    if (ef >= 0) check(req, "rl_free vs requirement", int'(rl_free), ef);
    check(req, "q_elim vs model", int'(q_elim), pe);
    check(req, "rl_free vs model", int'(rl_free), pf);
    @(posedge clk);
    model_update(qv, qt, mv, mt, rv, rt, fl);
    @(negedge clk);
  endtask

  task automatic q(int t, int ee, string req);
    step(1, t, 0, 0, 0, 0, 0, ee, -1, req);
  endtask

  task automatic rel(int t, int ef, string req);
    step(0, 0, 0, 0, 1, t, 0, -1, ef, req);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned lcg;
    for (int i = 0; i < SLOTS; i++) begin m_tag[i] = 0; m_spec[i] = 0; m_ret[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rel(3, 1, "R1");
    q(3, 1, "R1");                    // R2: allocate tag 3 with 2 refs
    // R3 then R4 at the cap of 3
    q(3, 1, "R3");
    q(3, 0, "R4");
    q(3, 0, "R4");
    // R6: release down to a single reference
    rel(3, 0, "R6");
    rel(3, 0, "R6");
    rel(3, 1, "R6");
    step(0, 0, 0, 0, 0, 3, 0, 0, 0, "R6");   // rl_valid low
    // R9: idle query leaves tag 9 untracked
    step(0, 9, 0, 0, 0, 0, 0, 0, -1, "R9");
    rel(9, 1, "R9");
    // R5: fill all slots
    for (int t = 0; t < SLOTS; t++) q(t, 1, "R5");
    q(8, 0, "R5");
    rel(1, 0, "R5");                  // frees tag 1 slot
    q(8, 1, "R5");
    q(1, 0, "R5");
    // clean: release 0,2,3,8
    rel(0, 0, "R6"); rel(2, 0, "R6"); rel(3, 0, "R6"); rel(8, 0, "R6");
    // R7/R8: tag 7 move retired, tag 6 not
    q(7, 1, "R8");
    q(6, 1, "R8");
    step(0, 0, 1, 7, 0, 0, 0, 0, -1, "R7");   // ret of 7 -> 2
    step(0, 0, 1, 5, 0, 0, 0, 0, -1, "R7");   // untracked: no effect
    rel(5, 1, "R7");
    q(7, 1, "R8");                    // spec 7 -> 3
    step(1, 7, 0, 0, 0, 0, 1, 0, -1, "R8");   // flush: 7 -> 2, 6 freed
    rel(6, 1, "R8");
    q(7, 1, "R8");                    // back to 3
    q(7, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 0, -1, "R8");   // flush again: 7 -> 2
    rel(7, 0, "R8");
    rel(7, 1, "R8");

    // pseudo-random sweep against the count model
    lcg = 32'h1234_5678;
    for (int c = 0; c < 4000; c++) begin
      bit qv, mv, rv, fl;
      int qt, mt, rt;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      qv = (lcg[31:30] != 2'b00);
      qt = int'(lcg[29:27]) % 6;
      mv = (lcg[26:25] == 2'b11);
      mt = int'(lcg[24:22]) % 6;
      rv = (lcg[21:20] != 2'b00) && lcg[19];
      rt = int'(lcg[18:16]) % 6;
      fl = (lcg[15:11] == 5'd0);
      step(qv, qt, mv, mt, rv, rt, fl, -1, -1, "R3 sweep");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule